// File: doc/BRIEF.md
# Hit Pattern Event Recorder

The block records hit patterns from a 64-channel detector front end during a particle bunch train and ships them out afterwards over one serial line. Each channel delivers two discriminator levels. A 24-bit crossing counter advances on every bunch-crossing pulse. On any crossing where at least one discriminator bit is set, the block stores one record: the levels of every channel, the counter value and an 8-bit chip header taken from configuration.

Up to 128 records fit in the on-chip store. When the store is full, a flag is raised and further hits are dropped until the next start of acquisition.

After the train, a readout command sends every stored record in write order. The line runs at one of two bit rates chosen by configuration. A one-cycle completion pulse follows the last bit. Readout leaves the store intact. A start-of-acquisition command clears the store and the crossing counter.

Top module: `hit_event_recorder`

## Requirements
- R1: After reset, `ser_o`, `ser_valid_o`, `busy_o`, `ro_done_o` and `full_o` are all 0, and the store is empty.
- R2: The crossing counter advances by one on each cycle with `bx_i` high and returns to 0 on `acq_start_i`. `acq_start_i` wins over `bx_i`. A record carries the counter value of its own crossing, so the first crossing after a clear is numbered 0.
- R3: A crossing with `hit_i` all zero writes no record.
- R4: A record holds all of `hit_i` (channel c uses bits 2c+1 and 2c), whether or not each channel fired, plus the `chip_id_i` value present at that crossing.
- R5: Once DEPTH records are stored, `full_o` is 1 and further hits are not stored until `acq_start_i`.
- R6: Each record is sent as follows: the header MSB first, then the crossing ID MSB first, then the channels from N_CH-1 down to 0, with bit 2c+1 before bit 2c.
- R7: Each bit stays on `ser_o` with `ser_valid_o` high for FAST_DIV cycles when `fast_i` was 1 at the command, and for SLOW_DIV cycles when it was 0. Each record is preceded by one busy cycle with `ser_valid_o` low.
- R8: Records leave in the order they were written. `ro_done_o` pulses for one cycle, in the cycle after the last bit. With an empty store it pulses in the cycle after the command.
- R9: While `busy_o` is high, crossings with hits write no record.
- R10: Readout does not erase the store, so a second readout repeats the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_start_i | input | 1 | Clears the crossing counter and the store |
| bx_i | input | 1 | One-cycle bunch-crossing pulse |
| hit_i | input | 2*N_CH | Discriminator levels, two bits per channel |
| chip_id_i | input | HDR_W | Configured chip header |
| ro_start_i | input | 1 | Readout command, taken only when idle |
| fast_i | input | 1 | Bit-rate select: 1 fast, 0 slow |
| ser_o | output | 1 | Serial data |
| ser_valid_o | output | 1 | A data bit is on `ser_o` |
| busy_o | output | 1 | Readout in progress |
| ro_done_o | output | 1 | One-cycle end-of-readout pulse |
| full_o | output | 1 | Store holds DEPTH records |

## Verification
The in-line assertions check the following on every cycle:
- the crossing counter holds when there is no pulse and clears on command;
- the record count never moves while the store is full or a readout is running;
- a crossing with no hit never adds a record;
- a serial bit holds until its period ends;
- the completion pulse lasts one cycle and only occurs when the block is idle.

Only the bench scenarios can show the rest:
- the record contents and the exact bit order;
- the period length at both rates and the gap between records;
- the write order;
- that a second readout reproduces the first.

// File: rtl/hit_rec_pkg.sv
package hit_rec_pkg;
  typedef enum logic [1:0] {
    RO_IDLE  = 2'd0,
    RO_LOAD  = 2'd1,
    RO_SHIFT = 2'd2
  } ro_state_e;
endpackage

// File: rtl/bx_counter.sv
module bx_counter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !tick_i |=> $stable(cnt_o));
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/event_mem.sv
module event_mem #(
  parameter int WORD_W = 160,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign full_o    = (count_o == CW'(DEPTH));
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[count_o[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clr_i)   count_o <= '0;
    else if (wr_en_i) count_o <= count_o + 1'b1;
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clr_i |=> $stable(count_o));
  assert_write_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import hit_rec_pkg::*;
#(
  parameter int WORD_W   = 160,
  parameter int DEPTH    = 128,
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 40,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int BW     = $clog2(WORD_W),
  localparam int MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV,
  localparam int DW     = $clog2(MAXDIV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fast_i,
  input  logic [CW-1:0]     count_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              ser_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o
);
  ro_state_e         state_q;
  logic [WORD_W-1:0] sreg_q;
  logic [BW-1:0]     bit_q;
  logic [DW-1:0]     div_q;
  logic [CW-1:0]     n_q;
  logic              fast_q;
  logic [DW-1:0]     per_m1;

  assign per_m1    = fast_q ? DW'(FAST_DIV - 1) : DW'(SLOW_DIV - 1);
  assign valid_o   = (state_q == RO_SHIFT);
  assign busy_o    = (state_q != RO_IDLE);
  assign ser_o     = valid_o & sreg_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RO_IDLE;
      sreg_q    <= '0;
      bit_q     <= '0;
      div_q     <= '0;
      n_q       <= '0;
      fast_q    <= 1'b0;
      rd_addr_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        RO_IDLE: if (start_i) begin
          fast_q    <= fast_i;
          n_q       <= count_i;
          rd_addr_o <= '0;
          if (count_i == '0) done_o  <= 1'b1;
          else               state_q <= RO_LOAD;
        end
        RO_LOAD: begin
          sreg_q  <= rd_data_i;
          bit_q   <= '0;
          div_q   <= '0;
          state_q <= RO_SHIFT;
        end
        RO_SHIFT: begin
          if (div_q == per_m1) begin
            div_q  <= '0;
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            if (bit_q == BW'(WORD_W - 1)) begin
              bit_q <= '0;
              if (CW'(rd_addr_o) == n_q - 1'b1) begin
                state_q <= RO_IDLE;
                done_o  <= 1'b1;
              end else begin
                rd_addr_o <= rd_addr_o + 1'b1;
                state_q   <= RO_LOAD;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= RO_IDLE;
      endcase
    end
  end

  assert_bit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && div_q != per_m1 |=> valid_o && $stable(ser_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/hit_event_recorder.sv
module hit_event_recorder #(
  parameter int N_CH     = 64,
  parameter int BCID_W   = 24,
  parameter int HDR_W    = 8,
  parameter int DEPTH    = 128,
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acq_start_i,
  input  logic              bx_i,
  input  logic [2*N_CH-1:0] hit_i,
  input  logic [HDR_W-1:0]  chip_id_i,
  input  logic              ro_start_i,
  input  logic              fast_i,
  output logic              ser_o,
  output logic              ser_valid_o,
  output logic              busy_o,
  output logic              ro_done_o,
  output logic              full_o
);
  localparam int WORD_W = HDR_W + BCID_W + 2 * N_CH;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);

  logic [BCID_W-1:0] bcid;
  logic [WORD_W-1:0] rd_data;
  logic [AW-1:0]     rd_addr;
  logic [CW-1:0]     count;
  logic              wr_en;

  assign wr_en = bx_i & (|hit_i) & ~full_o & ~busy_o & ~acq_start_i;

  bx_counter #(.W(BCID_W)) i_bx_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acq_start_i),
    .tick_i (bx_i),
    .cnt_o  (bcid)
  );

  event_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_event_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (acq_start_i),
    .wr_en_i   (wr_en),
    .wr_data_i ({chip_id_i, bcid, hit_i}),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .count_o   (count),
    .full_o    (full_o)
  );

  ser_shifter #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) i_ser_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ro_start_i),
    .fast_i    (fast_i),
    .count_i   (count),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .ser_o     (ser_o),
    .valid_o   (ser_valid_o),
    .busy_o    (busy_o),
    .done_o    (ro_done_o)
  );

  assert_skip_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i == '0 && !acq_start_i |=> $stable(count));
  assert_busy_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !acq_start_i |=> $stable(count));
endmodule

// File: tb/test_hit_event_recorder.sv
module test_hit_event_recorder;
  localparam int N_CH = 4, BCID_W = 24, HDR_W = 8, DEPTH = 4;
  localparam int FAST_DIV = 2, SLOW_DIV = 3;
  localparam int W = HDR_W + BCID_W + 2 * N_CH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acq_start = 0, bx = 0, ro_start = 0, fast = 0;
  logic [2*N_CH-1:0] hit = '0;
  logic [HDR_W-1:0]  chip_id = '0;
  logic ser, ser_valid, busy, ro_done, full;

  int checks = 0, errors = 0;
  logic [W-1:0]      exp_word [DEPTH];
  int                exp_n = 0;
  logic [BCID_W-1:0] m_bcid = '0;

  always #5 clk = ~clk;

  hit_event_recorder #(
    .N_CH(N_CH), .BCID_W(BCID_W), .HDR_W(HDR_W), .DEPTH(DEPTH),
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) i_hit_event_recorder (
    .clk_i(clk), .rst_ni(rst_n), .acq_start_i(acq_start), .bx_i(bx),
    .hit_i(hit), .chip_id_i(chip_id), .ro_start_i(ro_start), .fast_i(fast),
    .ser_o(ser), .ser_valid_o(ser_valid), .busy_o(busy),
    .ro_done_o(ro_done), .full_o(full)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acq_clear();
    @(negedge clk); acq_start = 1;
    @(negedge clk); acq_start = 0;
    m_bcid = '0; exp_n = 0;
  endtask

  task automatic crossing(input logic [2*N_CH-1:0] pat, input logic [HDR_W-1:0] hdr);
    @(negedge clk); hit = pat; chip_id = hdr; bx = 1;
    @(negedge clk); bx = 0; hit = '0;
    if (pat != '0 && exp_n < DEPTH) begin
      exp_word[exp_n] = {hdr, m_bcid, pat};
      exp_n++;
    end
    m_bcid++;
  endtask

  // inject_at > 0 drives a hit crossing during readout (R9)
  task automatic readout(input bit f, input int inject_at);
    int per;
    int busy_cyc, guard, mism, first_bad;
    bit prev_valid, done_seen, done_ok;
    bit bits [$];
    per = f ? FAST_DIV : SLOW_DIV;
    busy_cyc = 0; guard = 0; mism = 0; first_bad = -1;
    prev_valid = 0; done_seen = 0; done_ok = 0;
    @(negedge clk); ro_start = 1; fast = f;
    while (!done_seen && guard < 20000) begin
      @(negedge clk);
      ro_start = 0;
      guard++;
      if (guard == inject_at) begin bx = 1; hit = '1; end
      else if (inject_at > 0 && guard == inject_at + 1) begin bx = 0; hit = '0; m_bcid++; end
      if (ser_valid) bits.push_back(ser);
      if (busy) busy_cyc++;
      if (ro_done) begin
        done_seen = 1;
        done_ok = (exp_n == 0) ? (guard == 1) : prev_valid;
      end
      prev_valid = ser_valid;
    end
    chk(done_seen && done_ok, "R8 done pulse", longint'(guard), 0);
    chk(busy_cyc == exp_n * (W * per + 1), "R7 busy cycles", busy_cyc, exp_n * (W * per + 1));
    chk(bits.size() == exp_n * W * per, "R7 bit count", bits.size(), exp_n * W * per);
    if (bits.size() == exp_n * W * per) begin
      for (int i = 0; i < bits.size(); i++) begin
        int r, k;
        r = i / (W * per);
        k = (i % (W * per)) / per;
        if (bits[i] !== exp_word[r][W-1-k]) begin
          mism++;
          if (first_bad < 0) first_bad = i;
        end
      end
    end
    chk(mism == 0, "R4 R6 stream content", first_bad, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser == 0, "R1 ser", ser, 0);
    chk(ser_valid == 0, "R1 valid", ser_valid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ro_done == 0, "R1 done", ro_done, 0);
    chk(full == 0, "R1 full", full, 0);
    rst_n = 1;
    // R1/R8 empty store readout
    readout(1, 0);

    // R3 only empty crossings
    acq_clear();
    for (int k = 0; k < 5; k++) crossing('0, 8'h5A);
    readout(0, 0);

    // sweep: R2 R4 R5 R6 R7 R8
    for (int a = 0; a < 16; a++) begin
      acq_clear();
      for (int k = 0; k < 6; k++) begin
        logic [2*N_CH-1:0] pat;
        pat = (k % 3 == 1) ? '0 : (2*N_CH)'((a * 37 + k * 53 + 1) & 8'hFF);
        crossing(pat, HDR_W'(a * 16 + k));
      end
      @(negedge clk);
      chk(full == (exp_n == DEPTH), "R5 full flag", full, exp_n == DEPTH);
      readout(a[0], 0);
    end

    // R5 overflow ignored
    acq_clear();
    for (int k = 0; k < DEPTH + 3; k++) crossing((2*N_CH)'(k + 1), 8'hC3);
    @(negedge clk);
    chk(full == 1, "R5 full set", full, 1);
    readout(1, 0);
    acq_clear();
    @(negedge clk);
    chk(full == 0, "R5 full cleared", full, 0);

    // R2 crossing ID after idle crossings
    crossing('0, 8'h11); crossing('0, 8'h11); crossing('0, 8'h11);
    crossing(8'h81, 8'h22);
    readout(0, 0);

    // R9 hit during readout, R10 repeated readout
    acq_clear();
    crossing(8'h0F, 8'hA5);
    crossing(8'hF0, 8'h5A);
    readout(1, 3);
    readout(0, 0);
    chk(full == 0, "R9 R10 store unchanged", full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule